// File: doc/BRIEF.md
# Clock Output Stop and Enable Controller

This block decides, for every clock output of a board clock generator, which of four drive states the pad should take: running, held low, floated, or parked high. Its inputs are three active-low control pins (power-down, CPU-clock stop and PCI-clock stop), per-output configuration bits from a register file, and the level of each group's already-divided source clock. The block does not make any clock itself. Oscillators, dividers and pad drivers sit outside it and read the 2-bit code from this block.

The control pins pass through two synchronizer flops. Each output's code is held in a register that loads only on an edge where the group's source clock is low. A clock therefore stops only after its high phase is complete, and it restarts at the start of a full cycle. The block also captures the frequency-select and multiplier straps the first time the active-low power-good strobe is sampled low. It reports the synchronized levels of the two stop pins back as status.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `rst` is high, every drive code is 00 (low), `strap_valid` is 0, `strap_sel_q`/`strap_mult_q` are 0, and both stop status bits are 1.
- R2: With all three control pins high and every enable bit 1, every drive code becomes 01 (running). This includes the CPU complement outputs.
- R3: When power-down is active, every CPU true output is 11 (parked high), or 10 (float) if `cfg_pd_float` is 1. Every CPU complement output is 10. Every PCI_F, PCI, 66 MHz and 48 MHz output is 00. Power-down overrides the enable and stop bits.
- R4: When PCI stop is active, every PCI output is 00. PCI_F output i is 00 only if `cfg_pcif_mask[i]` is 1; otherwise it keeps running. CPU, 66 MHz and 48 MHz outputs are not affected.
- R5: When CPU stop is active, CPU pair i goes to true 11 and complement 00, unless `cfg_cpu_free[i]` is 1, in which case both stay 01.
- R6: Outside power-down, an output whose enable bit is 0 is 00 (for a CPU pair, both halves), whatever the stop pins are.
- R7: When `cfg_pin24_in` is 1, the enable bit of the last 66 MHz output (index N_66-1) is ignored and that output keeps running.
- R8: A group's drive codes change only on a clock edge where that group's source level is 0. A stop requested while the source is high waits until the source goes low.
- R9: A control-pin change made between edges reaches the drive codes on the third rising edge after it, provided the source is low. It has no effect after the second edge.
- R10: On the first edge that samples `pwr_good_n` low, `strap_sel`/`strap_mult` are captured and `strap_valid` rises. Later changes on the straps or on `pwr_good_n` are ignored until reset.
- R11: `cpu_stop_sts` and `pci_stop_sts` show the levels of the stop pins two rising edges after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dwn_n | input | 1 | Power-down pin, active low |
| cpu_stop_n | input | 1 | CPU clock stop pin, active low |
| pci_stop_n | input | 1 | PCI clock stop pin, active low |
| pwr_good_n | input | 1 | Strap capture strobe, active low |
| strap_sel | input | SEL_W | Frequency-select straps |
| strap_mult | input | 1 | Current-multiplier strap |
| cfg_pd_float | input | 1 | Float CPU true outputs in power-down |
| cfg_cpu_en | input | N_CPU | Per CPU pair enable |
| cfg_cpu_free | input | N_CPU | Per CPU pair free-run under CPU stop |
| cfg_pcif_en | input | N_PCIF | Per PCI_F enable |
| cfg_pcif_mask | input | N_PCIF | PCI_F stops with PCI stop when 1 |
| cfg_pci_en | input | N_PCI | Per PCI enable |
| cfg_66_en | input | N_66 | Per 66 MHz output enable |
| cfg_48_en | input | N_48 | Per 48 MHz output enable |
| cfg_pin24_in | input | 1 | Last 66 MHz pin is used as an input |
| src_cpu | input | 1 | CPU group source clock level |
| src_pcif | input | 1 | PCI_F group source clock level |
| src_pci | input | 1 | PCI group source clock level |
| src_66 | input | 1 | 66 MHz group source clock level |
| src_48 | input | 1 | 48 MHz group source clock level |
| drv_cpu_t | output | 2*N_CPU | CPU true output drive codes |
| drv_cpu_c | output | 2*N_CPU | CPU complement output drive codes |
| drv_pcif | output | 2*N_PCIF | PCI_F drive codes |
| drv_pci | output | 2*N_PCI | PCI drive codes |
| drv_66 | output | 2*N_66 | 66 MHz drive codes |
| drv_48 | output | 2*N_48 | 48 MHz drive codes |
| strap_sel_q | output | SEL_W | Captured select straps |
| strap_mult_q | output | 1 | Captured multiplier strap |
| strap_valid | output | 1 | Straps have been captured |
| cpu_stop_sts | output | 1 | Synchronized CPU stop pin level |
| pci_stop_sts | output | 1 | Synchronized PCI stop pin level |

## Verification
The checker assumes that each source-level input is a clean level in the block's own clock domain. It also assumes that reset is asserted from time zero, so that every past value it refers to comes from after reset. The bench drives all inputs on the falling edge and keeps source levels low, except in the test that deliberately holds one high to delay a stop. The strobe and strap inputs are changed only between edges, which keeps the capture edge unambiguous.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  typedef enum logic [1:0] {
    DRV_LOW  = 2'b00,
    DRV_RUN  = 2'b01,
    DRV_FLT  = 2'b10,
    DRV_HIGH = 2'b11
  } drv_e;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '1;
      q    <= '1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pg_n,
  input  logic [W-1:0] straps,
  output logic [W-1:0] q,
  output logic         valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      valid <= 1'b0;
    end else if (!valid && !pg_n) begin
      q     <= straps;
      valid <= 1'b1;
    end
  end
endmodule

// File: rtl/drive_gate.sv
module drive_gate #(
  parameter int N = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           src,
  input  logic [2*N-1:0] tgt,
  output logic [2*N-1:0] drv
);
  // codes load only while the source sits in its low phase
  for (genvar i = 0; i < N; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst)
        drv[2*i +: 2] <= clk_stop_pkg::DRV_LOW;
      else if (!src)
        drv[2*i +: 2] <= tgt[2*i +: 2];
    end
  end
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int N_CPU  = 3,
  parameter int N_PCIF = 3,
  parameter int N_PCI  = 7,
  parameter int N_66   = 6,
  parameter int N_48   = 2,
  parameter int SEL_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pwr_dwn_n,
  input  logic                cpu_stop_n,
  input  logic                pci_stop_n,
  input  logic                pwr_good_n,
  input  logic [SEL_W-1:0]    strap_sel,
  input  logic                strap_mult,
  input  logic                cfg_pd_float,
  input  logic [N_CPU-1:0]    cfg_cpu_en,
  input  logic [N_CPU-1:0]    cfg_cpu_free,
  input  logic [N_PCIF-1:0]   cfg_pcif_en,
  input  logic [N_PCIF-1:0]   cfg_pcif_mask,
  input  logic [N_PCI-1:0]    cfg_pci_en,
  input  logic [N_66-1:0]     cfg_66_en,
  input  logic [N_48-1:0]     cfg_48_en,
  input  logic                cfg_pin24_in,
  input  logic                src_cpu,
  input  logic                src_pcif,
  input  logic                src_pci,
  input  logic                src_66,
  input  logic                src_48,
  output logic [2*N_CPU-1:0]  drv_cpu_t,
  output logic [2*N_CPU-1:0]  drv_cpu_c,
  output logic [2*N_PCIF-1:0] drv_pcif,
  output logic [2*N_PCI-1:0]  drv_pci,
  output logic [2*N_66-1:0]   drv_66,
  output logic [2*N_48-1:0]   drv_48,
  output logic [SEL_W-1:0]    strap_sel_q,
  output logic                strap_mult_q,
  output logic                strap_valid,
  output logic                cpu_stop_sts,
  output logic                pci_stop_sts
);
  import clk_stop_pkg::*;

  localparam int IN66_IDX = N_66 - 1;
  localparam int STRAP_W  = SEL_W + 1;

  logic [2:0] pins_s;
  logic       pd_n_s, cstop_n_s, pstop_n_s;
  logic [2*N_CPU-1:0]  tgt_cpu_t, tgt_cpu_c;
  logic [2*N_PCIF-1:0] tgt_pcif;
  logic [2*N_PCI-1:0]  tgt_pci;
  logic [2*N_66-1:0]   tgt_66;
  logic [2*N_48-1:0]   tgt_48;

  ctl_sync #(.N(3)) u_sync (
    .clk(clk), .rst(rst),
    .d({pwr_dwn_n, cpu_stop_n, pci_stop_n}),
    .q(pins_s)
  );
  assign pd_n_s    = pins_s[2];
  assign cstop_n_s = pins_s[1];
  assign pstop_n_s = pins_s[0];
  assign cpu_stop_sts = cstop_n_s;
  assign pci_stop_sts = pstop_n_s;

  strap_capture #(.W(STRAP_W)) u_strap (
    .clk(clk), .rst(rst), .pg_n(pwr_good_n),
    .straps({strap_mult, strap_sel}),
    .q({strap_mult_q, strap_sel_q}),
    .valid(strap_valid)
  );

  // precedence: power-down, then enable, then stop pins
  always_comb begin
    for (int i = 0; i < N_CPU; i++) begin
      if (!pd_n_s) begin
        tgt_cpu_t[2*i +: 2] = cfg_pd_float ? DRV_FLT : DRV_HIGH;
        tgt_cpu_c[2*i +: 2] = DRV_FLT;
      end else if (!cfg_cpu_en[i]) begin
        tgt_cpu_t[2*i +: 2] = DRV_LOW;
        tgt_cpu_c[2*i +: 2] = DRV_LOW;
      end else if (!cstop_n_s && !cfg_cpu_free[i]) begin
        tgt_cpu_t[2*i +: 2] = DRV_HIGH;
        tgt_cpu_c[2*i +: 2] = DRV_LOW;
      end else begin
        tgt_cpu_t[2*i +: 2] = DRV_RUN;
        tgt_cpu_c[2*i +: 2] = DRV_RUN;
      end
    end
    for (int i = 0; i < N_PCIF; i++)
      tgt_pcif[2*i +: 2] = (!pd_n_s || !cfg_pcif_en[i] ||
                            (!pstop_n_s && cfg_pcif_mask[i])) ? DRV_LOW : DRV_RUN;
    for (int i = 0; i < N_PCI; i++)
      tgt_pci[2*i +: 2] = (!pd_n_s || !cfg_pci_en[i] || !pstop_n_s) ? DRV_LOW : DRV_RUN;
    for (int i = 0; i < N_66; i++)
      tgt_66[2*i +: 2] = (!pd_n_s ||
                          (!cfg_66_en[i] && !(i == IN66_IDX && cfg_pin24_in))) ? DRV_LOW : DRV_RUN;
    for (int i = 0; i < N_48; i++)
      tgt_48[2*i +: 2] = (!pd_n_s || !cfg_48_en[i]) ? DRV_LOW : DRV_RUN;
  end

  drive_gate #(.N(N_CPU)) u_g_cpu_t (.clk(clk), .rst(rst), .src(src_cpu), .tgt(tgt_cpu_t), .drv(drv_cpu_t));
  drive_gate #(.N(N_CPU)) u_g_cpu_c (.clk(clk), .rst(rst), .src(src_cpu), .tgt(tgt_cpu_c), .drv(drv_cpu_c));
  drive_gate #(.N(N_PCIF)) u_g_pcif (.clk(clk), .rst(rst), .src(src_pcif), .tgt(tgt_pcif), .drv(drv_pcif));
  drive_gate #(.N(N_PCI))  u_g_pci  (.clk(clk), .rst(rst), .src(src_pci), .tgt(tgt_pci), .drv(drv_pci));
  drive_gate #(.N(N_66))   u_g_66   (.clk(clk), .rst(rst), .src(src_66), .tgt(tgt_66), .drv(drv_66));
  drive_gate #(.N(N_48))   u_g_48   (.clk(clk), .rst(rst), .src(src_48), .tgt(tgt_48), .drv(drv_48));
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk #(
  parameter int N_CPU = 3,
  parameter int N_PCI = 7,
  parameter int SEL_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               pd_n_s,
  input logic               src_cpu,
  input logic               src_pci,
  input logic [2*N_CPU-1:0] drv_cpu_t,
  input logic [2*N_CPU-1:0] drv_cpu_c,
  input logic [2*N_PCI-1:0] drv_pci,
  input logic               strap_valid,
  input logic [SEL_W-1:0]   strap_sel_q
);
  // R8
  cpu_whole_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (drv_cpu_t != $past(drv_cpu_t)) |-> !$past(src_cpu));
  // R8
  pci_whole_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (drv_pci != $past(drv_pci)) |-> !$past(src_pci));
  // R3
  pd_pci_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!pd_n_s && !src_pci) |=> (drv_pci == '0));
  // R3
  pd_cpu_c_float_chk: assert property (@(posedge clk) disable iff (rst)
    (!pd_n_s && !src_cpu) |=> (drv_cpu_c == {N_CPU{2'b10}}));
  // R10
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    strap_valid |=> (strap_valid && $stable(strap_sel_q)));
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .pd_n_s(pd_n_s), .src_cpu(src_cpu), .src_pci(src_pci),
  .drv_cpu_t(drv_cpu_t), .drv_cpu_c(drv_cpu_c), .drv_pci(drv_pci),
  .strap_valid(strap_valid), .strap_sel_q(strap_sel_q)
);

// File: tb/test_clk_stop_ctrl.sv
`timescale 1ns/1ps
module test_clk_stop_ctrl;
  localparam int N_CPU = 3, N_PCIF = 3, N_PCI = 7, N_66 = 6, N_48 = 2, SEL_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_dwn_n = 1, cpu_stop_n = 1, pci_stop_n = 1, pwr_good_n = 1;
  logic [SEL_W-1:0] strap_sel = '0;
  logic strap_mult = 0, cfg_pd_float = 0, cfg_pin24_in = 0;
  logic [N_CPU-1:0] cfg_cpu_en = '1, cfg_cpu_free = '0;
  logic [N_PCIF-1:0] cfg_pcif_en = '1, cfg_pcif_mask = '0;
  logic [N_PCI-1:0] cfg_pci_en = '1;
  logic [N_66-1:0] cfg_66_en = '1;
  logic [N_48-1:0] cfg_48_en = '1;
  logic src_cpu = 0, src_pcif = 0, src_pci = 0, src_66 = 0, src_48 = 0;
  logic [2*N_CPU-1:0] drv_cpu_t, drv_cpu_c;
  logic [2*N_PCIF-1:0] drv_pcif;
  logic [2*N_PCI-1:0] drv_pci;
  logic [2*N_66-1:0] drv_66;
  logic [2*N_48-1:0] drv_48;
  logic [SEL_W-1:0] strap_sel_q;
  logic strap_mult_q, strap_valid, cpu_stop_sts, pci_stop_sts;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  clk_stop_ctrl i_clk_stop_ctrl (.*);

  function automatic logic [31:0] rep(input logic [1:0] c, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[2*i +: 2] = c;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    // R1
    chk("R1 cpu_t", 32'(drv_cpu_t), 0);
    chk("R1 pci", 32'(drv_pci), 0);
    chk("R1 strap_valid", 32'(strap_valid), 0);
    chk("R1 sts", {30'd0, cpu_stop_sts, pci_stop_sts}, 32'd3);
  endtask

  task automatic t_run();
    // R2
    chk("R2 cpu_t", 32'(drv_cpu_t), rep(2'b01, N_CPU));
    chk("R2 cpu_c", 32'(drv_cpu_c), rep(2'b01, N_CPU));
    chk("R2 pcif", 32'(drv_pcif), rep(2'b01, N_PCIF));
    chk("R2 pci", 32'(drv_pci), rep(2'b01, N_PCI));
    chk("R2 66", 32'(drv_66), rep(2'b01, N_66));
    chk("R2 48", 32'(drv_48), rep(2'b01, N_48));
  endtask

  task automatic t_straps();
    // R10
    strap_sel = 3'b101; strap_mult = 1; pwr_good_n = 0;
    @(posedge clk); @(negedge clk);
    chk("R10 captured", {27'd0, strap_valid, strap_mult_q, strap_sel_q}, {27'd0, 2'b11, 3'b101});
    strap_sel = 3'b010; strap_mult = 0; pwr_good_n = 1;
    repeat (2) @(negedge clk);
    pwr_good_n = 0;
    repeat (2) @(negedge clk);
    chk("R10 ignored", {27'd0, strap_valid, strap_mult_q, strap_sel_q}, {27'd0, 2'b11, 3'b101});
  endtask

  task automatic t_latency_status();
    // R9 and R11
    pci_stop_n = 0;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R11 sts after 2 edges", 32'(pci_stop_sts), 0);
    chk("R9 no change after 2 edges", 32'(drv_pci), rep(2'b01, N_PCI));
    @(posedge clk); @(negedge clk);
    chk("R9 change on 3rd edge", 32'(drv_pci), 0);
    pci_stop_n = 1; settle();
  endtask

  task automatic t_pci_stop();
    // R4
    cfg_pcif_mask = 3'b010; pci_stop_n = 0; settle();
    chk("R4 pci", 32'(drv_pci), 0);
    chk("R4 pcif", 32'(drv_pcif), {26'd0, 2'b01, 2'b00, 2'b01});
    chk("R4 cpu unaffected", 32'(drv_cpu_t), rep(2'b01, N_CPU));
    chk("R4 66 unaffected", 32'(drv_66), rep(2'b01, N_66));
    pci_stop_n = 1; cfg_pcif_mask = '0; settle();
  endtask

  task automatic t_cpu_stop();
    // R5
    cfg_cpu_free = 3'b001; cpu_stop_n = 0; settle();
    chk("R5 cpu_t", 32'(drv_cpu_t), {26'd0, 2'b11, 2'b11, 2'b01});
    chk("R5 cpu_c", 32'(drv_cpu_c), {26'd0, 2'b00, 2'b00, 2'b01});
    chk("R5 pci unaffected", 32'(drv_pci), rep(2'b01, N_PCI));
    chk("R11 cpu sts", 32'(cpu_stop_sts), 0);
    cpu_stop_n = 1; cfg_cpu_free = '0; settle();
  endtask

  task automatic t_enable();
    // R6 and R7
    cfg_cpu_en = 3'b101; cfg_pci_en = 7'b1111110; cfg_48_en = 2'b01;
    cfg_66_en = 6'b011110; cfg_pin24_in = 1; pci_stop_n = 0; settle();
    chk("R6 cpu_t", 32'(drv_cpu_t), {26'd0, 2'b01, 2'b00, 2'b01});
    chk("R6 cpu_c", 32'(drv_cpu_c), {26'd0, 2'b01, 2'b00, 2'b01});
    chk("R6 48", 32'(drv_48), {28'd0, 2'b00, 2'b01});
    chk("R6 pci", 32'(drv_pci), 0);
    chk("R7 pin24 kept", 32'(drv_66), {20'd0, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b00});
    cfg_pin24_in = 0; settle();
    chk("R7 pin24 gated", 32'(drv_66), {20'd0, 2'b00, 2'b01, 2'b01, 2'b01, 2'b01, 2'b00});
    cfg_cpu_en = '1; cfg_pci_en = '1; cfg_48_en = '1; cfg_66_en = '1; pci_stop_n = 1; settle();
  endtask

  task automatic t_powerdown();
    // R3
    cfg_pci_en = 7'b0; cpu_stop_n = 0; pwr_dwn_n = 0; settle();
    chk("R3 cpu_t park", 32'(drv_cpu_t), rep(2'b11, N_CPU));
    chk("R3 cpu_c float", 32'(drv_cpu_c), rep(2'b10, N_CPU));
    chk("R3 pcif", 32'(drv_pcif), 0);
    chk("R3 66", 32'(drv_66), 0);
    chk("R3 48", 32'(drv_48), 0);
    cfg_pd_float = 1; settle();
    chk("R3 cpu_t float", 32'(drv_cpu_t), rep(2'b10, N_CPU));
    pwr_dwn_n = 1; cpu_stop_n = 1; cfg_pd_float = 0; cfg_pci_en = '1; settle();
    chk("R2 after pd", 32'(drv_pci), rep(2'b01, N_PCI));
  endtask

  task automatic t_whole_cycle();
    // R8
    src_pci = 1; pci_stop_n = 0;
    repeat (6) @(posedge clk); @(negedge clk);
    chk("R8 held while src high", 32'(drv_pci), rep(2'b01, N_PCI));
    src_pci = 0;
    @(posedge clk); @(negedge clk);
    chk("R8 stops in low phase", 32'(drv_pci), 0);
    src_pci = 1; pci_stop_n = 1;
    repeat (6) @(posedge clk); @(negedge clk);
    chk("R8 restart waits", 32'(drv_pci), 0);
    src_pci = 0;
    @(posedge clk); @(negedge clk);
    chk("R8 restart", 32'(drv_pci), rep(2'b01, N_PCI));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 0;
    @(posedge clk); @(negedge clk);
    t_run();
    t_straps();
    t_latency_status();
    t_pci_stop();
    t_cpu_stop();
    t_enable();
    t_powerdown();
    t_whole_cycle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule